// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers a set of level-sensitive interrupt lines and drives two request outputs toward a processor: a normal request and a fast request. Each output has its own enable mask. An output is asserted whenever any source that is currently high is also enabled in that output's mask. No source is latched. A source counts as pending only while its line is held high, so the block does no priority encoding, vectoring or edge capture.

Software reaches the block through a word-indexed register bus. The register index is the byte offset divided by four. Each enable mask is changed only through a pair of indices, one that sets bits and one that clears bits, so separate software agents can change different bits without a read-modify-write. Source 0 also has a software flag. Setting the flag raises that source as if its line were high, which lets software post a request to itself. Both request outputs are registered and follow the register state and the source lines with one cycle of latency.

Top module: `dlic_top`

## Requirements
- R1: After reset both enable masks and the software flag are zero, and `irq_o` and `fiq_o` are low.
- R2: Reading index 1 or index 9 returns the raw level vector. The raw level is the source lines, with bit 0 ORed with the software flag.
- R3: Writing index 2 ORs the write data into the normal enable mask. Reading index 2 returns that mask.
- R4: Writing index 3 clears each normal enable bit whose write-data bit is 1 and leaves every other bit unchanged.
- R5: Writing index 10 sets fast enable bits and writing index 11 clears them, using the same bit rules as R3 and R4. Reading index 10 returns the fast mask.
- R6: Reading index 0 returns the raw level ANDed with the normal mask. Reading index 8 returns the raw level ANDed with the fast mask.
- R7: `irq_o` is 1 in the cycle after any bit of (raw level AND normal mask) is 1, and is 0 otherwise.
- R8: `fiq_o` is 1 in the cycle after any bit of (raw level AND fast mask) is 1, and is 0 otherwise.
- R9: Writing index 4 with data bit 0 set sets the software flag. Writing index 5 with data bit 0 set clears it. A write to either index with bit 0 clear has no effect. Reading index 4 returns raw-level bit 0 in bit 0 and zeros in all other bits.
- R10: Reading index 3, 5 or 11, or any index not listed in R2 to R9, returns zero.
- R11: Writes to indices 0, 1, 8 and 9, and to any index not listed in R3 to R9, leave both masks and the software flag unchanged.
- R12: A raw-level bit follows its source line. It clears as soon as the line drops, unless it is bit 0 and the software flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| src_lvl_i | input | NSRC (32) | Level-sensitive interrupt source lines |
| bus_wr_i | input | 1 | Write strobe; the write takes effect at the clock edge |
| bus_idx_i | input | IDX_W (6) | Register index (byte offset / 4) |
| bus_wdata_i | input | DW (32) | Write data |
| bus_rdata_o | output | DW (32) | Read data for `bus_idx_i`, combinational |
| irq_o | output | 1 | Registered normal request |
| fiq_o | output | 1 | Registered fast request |

## Verification
The request outputs are exercised in four situations: a source that is enabled in only one mask, a source that is enabled in neither mask, a source line that drops while it is still enabled, and source 0 driven by its line alone, by the software flag alone, and by both. Together these separate the normal path from the fast path, show that the block holds no latched state, and show that the software flag is ORed into bit 0. Set and clear writes are made with sparse data and with mostly-ones data, at bit 0 and at bit 31. This shows that only the bits addressed by the write change. A directed step samples the output one cycle after an enable write to confirm the registered latency. Reset is also applied in the middle of activity.

// File: rtl/dlic_pkg.sv
package dlic_pkg;
   // Register indices (byte offset / 4); software decodes these positions.
   localparam int unsigned MAP_IRQ_PEND   = 0;
   localparam int unsigned MAP_RAW_A      = 1;
   localparam int unsigned MAP_IRQ_EN_SET = 2;
   localparam int unsigned MAP_IRQ_EN_CLR = 3;
   localparam int unsigned MAP_SOFT_SET   = 4;
   localparam int unsigned MAP_SOFT_CLR   = 5;
   localparam int unsigned MAP_FIQ_PEND   = 8;
   localparam int unsigned MAP_RAW_B      = 9;
   localparam int unsigned MAP_FIQ_EN_SET = 10;
   localparam int unsigned MAP_FIQ_EN_CLR = 11;

   localparam int unsigned NUM_CH = 2;
   localparam int unsigned CH_IRQ = 0;
   localparam int unsigned CH_FIQ = 1;

   function automatic int unsigned set_index(input int unsigned ch);
      return (ch == CH_IRQ) ? MAP_IRQ_EN_SET : MAP_FIQ_EN_SET;
   endfunction

   function automatic int unsigned clr_index(input int unsigned ch);
      return (ch == CH_IRQ) ? MAP_IRQ_EN_CLR : MAP_FIQ_EN_CLR;
   endfunction
endpackage

// File: rtl/dlic_mask_reg.sv
module dlic_mask_reg #(
   parameter int unsigned NSRC    = 32,
   parameter int unsigned IDX_W   = 6,
   parameter int unsigned SET_IDX = 2,
   parameter int unsigned CLR_IDX = 3
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             wr_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [NSRC-1:0]  wdata_i,
   output logic [NSRC-1:0]  mask_o
);
   logic hit_set, hit_clr;

   assign hit_set = wr_i && (idx_i == IDX_W'(SET_IDX));
   assign hit_clr = wr_i && (idx_i == IDX_W'(CLR_IDX));

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         mask_o <= '0;
      end else if (hit_set) begin
         mask_o <= mask_o | wdata_i;
      end else if (hit_clr) begin
         mask_o <= mask_o & ~wdata_i;
      end
   end
endmodule

// File: rtl/dlic_soft_src.sv
module dlic_soft_src #(
   parameter int unsigned NSRC  = 32,
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             wr_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             wbit0_i,
   input  logic [NSRC-1:0]  src_i,
   output logic             soft_o,
   output logic [NSRC-1:0]  raw_o
);
   import dlic_pkg::*;

   logic do_set, do_clr;

   assign do_set = wr_i && wbit0_i && (idx_i == IDX_W'(MAP_SOFT_SET));
   assign do_clr = wr_i && wbit0_i && (idx_i == IDX_W'(MAP_SOFT_CLR));

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         soft_o <= 1'b0;
      end else if (do_set) begin
         soft_o <= 1'b1;
      end else if (do_clr) begin
         soft_o <= 1'b0;
      end
   end

   always_comb begin
      raw_o    = src_i;
      raw_o[0] = src_i[0] | soft_o;
   end
endmodule

// File: rtl/dlic_out_stage.sv
module dlic_out_stage #(
   parameter int unsigned NSRC = 32
) (
   input  logic            clk_i,
   input  logic            rst_n_i,
   input  logic [NSRC-1:0] raw_i,
   input  logic [NSRC-1:0] mask_i,
   output logic            req_o
);
   logic any_hit;

   assign any_hit = |(raw_i & mask_i);

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         req_o <= 1'b0;
      end else begin
         req_o <= any_hit;
      end
   end
endmodule

// File: rtl/dlic_top.sv
module dlic_top #(
   parameter int unsigned NSRC  = 32,
   parameter int unsigned DW    = 32,
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [NSRC-1:0]  src_lvl_i,
   input  logic             bus_wr_i,
   input  logic [IDX_W-1:0] bus_idx_i,
   input  logic [DW-1:0]    bus_wdata_i,
   output logic [DW-1:0]    bus_rdata_o,
   output logic             irq_o,
   output logic             fiq_o
);
   import dlic_pkg::*;

   generate
      if (NSRC < 1 || NSRC > DW) begin : g_bad_nsrc
         $error("dlic_top: NSRC must be between 1 and DW");
      end
      if (IDX_W < 4) begin : g_bad_idx
         $error("dlic_top: IDX_W must cover index 11");
      end
   endgenerate

   logic [NSRC-1:0] raw_lvl;
   logic            soft_flag;
   logic [NSRC-1:0] en_mask [NUM_CH];
   logic [NUM_CH-1:0] req;
   logic [NSRC-1:0] irq_en_w, fiq_en_w;

   dlic_soft_src #(.NSRC(NSRC), .IDX_W(IDX_W)) u_soft (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .wr_i    (bus_wr_i),
      .idx_i   (bus_idx_i),
      .wbit0_i (bus_wdata_i[0]),
      .src_i   (src_lvl_i),
      .soft_o  (soft_flag),
      .raw_o   (raw_lvl)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      dlic_mask_reg #(
         .NSRC    (NSRC),
         .IDX_W   (IDX_W),
         .SET_IDX (set_index(g)),
         .CLR_IDX (clr_index(g))
      ) u_mask (
         .clk_i   (clk_i),
         .rst_n_i (rst_n_i),
         .wr_i    (bus_wr_i),
         .idx_i   (bus_idx_i),
         .wdata_i (bus_wdata_i[NSRC-1:0]),
         .mask_o  (en_mask[g])
      );

      dlic_out_stage #(.NSRC(NSRC)) u_out (
         .clk_i   (clk_i),
         .rst_n_i (rst_n_i),
         .raw_i   (raw_lvl),
         .mask_i  (en_mask[g]),
         .req_o   (req[g])
      );
   end

   assign irq_en_w = en_mask[CH_IRQ];
   assign fiq_en_w = en_mask[CH_FIQ];
   assign irq_o    = req[CH_IRQ];
   assign fiq_o    = req[CH_FIQ];

   // Read selection, zero-extended to the bus width.
   logic [NSRC-1:0] rd_sel;

   always_comb begin
      case (bus_idx_i)
         IDX_W'(MAP_IRQ_PEND):   rd_sel = raw_lvl & irq_en_w;
         IDX_W'(MAP_RAW_A):      rd_sel = raw_lvl;
         IDX_W'(MAP_IRQ_EN_SET): rd_sel = irq_en_w;
         IDX_W'(MAP_SOFT_SET):   rd_sel = NSRC'(raw_lvl[0]);
         IDX_W'(MAP_FIQ_PEND):   rd_sel = raw_lvl & fiq_en_w;
         IDX_W'(MAP_RAW_B):      rd_sel = raw_lvl;
         IDX_W'(MAP_FIQ_EN_SET): rd_sel = fiq_en_w;
         default:                rd_sel = '0;
      endcase
      bus_rdata_o             = '0;
      bus_rdata_o[NSRC-1:0]   = rd_sel;
   end
endmodule

// File: rtl/dlic_checker.sv
module dlic_checker #(
   parameter int unsigned NSRC  = 32,
   parameter int unsigned DW    = 32,
   parameter int unsigned IDX_W = 6
) (
   input logic             clk_i,
   input logic             rst_n_i,
   input logic             bus_wr_i,
   input logic [IDX_W-1:0] bus_idx_i,
   input logic [DW-1:0]    bus_wdata_i,
   input logic [DW-1:0]    bus_rdata_o,
   input logic             irq_o,
   input logic             fiq_o,
   input logic [NSRC-1:0]  raw_lvl,
   input logic             soft_flag,
   input logic [NSRC-1:0]  irq_en_w,
   input logic [NSRC-1:0]  fiq_en_w
);
   import dlic_pkg::*;

   logic wr_set_i, wr_clr_i, wr_set_f, wr_clr_f, wr_soft, rd_zero;

   assign wr_set_i = bus_wr_i && (bus_idx_i == IDX_W'(MAP_IRQ_EN_SET));
   assign wr_clr_i = bus_wr_i && (bus_idx_i == IDX_W'(MAP_IRQ_EN_CLR));
   assign wr_set_f = bus_wr_i && (bus_idx_i == IDX_W'(MAP_FIQ_EN_SET));
   assign wr_clr_f = bus_wr_i && (bus_idx_i == IDX_W'(MAP_FIQ_EN_CLR));
   assign wr_soft  = bus_wr_i && (bus_idx_i == IDX_W'(MAP_SOFT_SET) ||
                                  bus_idx_i == IDX_W'(MAP_SOFT_CLR));
   assign rd_zero  = (bus_idx_i == IDX_W'(MAP_IRQ_EN_CLR)) ||
                     (bus_idx_i == IDX_W'(MAP_SOFT_CLR))   ||
                     (bus_idx_i == IDX_W'(MAP_FIQ_EN_CLR));

   // R7
   a_r7_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      1'b1 |=> (irq_o == |($past(raw_lvl & irq_en_w))));
   // R8
   a_r8_fiq_follows: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      1'b1 |=> (fiq_o == |($past(raw_lvl & fiq_en_w))));
   // R3
   a_r3_irq_en_set: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      wr_set_i |=> (irq_en_w == ($past(irq_en_w) | $past(bus_wdata_i[NSRC-1:0]))));
   // R4
   a_r4_irq_en_clr: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      wr_clr_i |=> (irq_en_w == ($past(irq_en_w) & ~$past(bus_wdata_i[NSRC-1:0]))));
   // R5
   a_r5_fiq_en_set: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      wr_set_f |=> (fiq_en_w == ($past(fiq_en_w) | $past(bus_wdata_i[NSRC-1:0]))));
   a_r5_fiq_en_clr: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      wr_clr_f |=> (fiq_en_w == ($past(fiq_en_w) & ~$past(bus_wdata_i[NSRC-1:0]))));
   // R11
   a_r11_irq_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !(wr_set_i || wr_clr_i) |=> $stable(irq_en_w));
   a_r11_fiq_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !(wr_set_f || wr_clr_f) |=> $stable(fiq_en_w));
   // R9
   a_r9_soft_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !wr_soft |=> $stable(soft_flag));
   a_r9_soft_raise: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (bus_wr_i && bus_idx_i == IDX_W'(MAP_SOFT_SET) && bus_wdata_i[0]) |=> soft_flag);
   // R10
   a_r10_zero_read: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      rd_zero |-> (bus_rdata_o == '0));
endmodule

bind dlic_top dlic_checker #(.NSRC(NSRC), .DW(DW), .IDX_W(IDX_W)) chk_i (
   .clk_i       (clk_i),
   .rst_n_i     (rst_n_i),
   .bus_wr_i    (bus_wr_i),
   .bus_idx_i   (bus_idx_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_rdata_o (bus_rdata_o),
   .irq_o       (irq_o),
   .fiq_o       (fiq_o),
   .raw_lvl     (raw_lvl),
   .soft_flag   (soft_flag),
   .irq_en_w    (irq_en_w),
   .fiq_en_w    (fiq_en_w)
);

// File: tb/dlic_top_tb_top.sv
`timescale 1ns/1ps
module dlic_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = '0;
   logic        wr = 1'b0;
   logic [5:0]  idx = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq, fiq;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;  // 200 MHz

   dlic_top dut_i (
      .clk_i       (clk),
      .rst_n_i     (rst_n),
      .src_lvl_i   (src),
      .bus_wr_i    (wr),
      .bus_idx_i   (idx),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq),
      .fiq_o       (fiq)
   );

   typedef struct packed {
      logic [31:0] src;
      logic [5:0]  widx;
      logic [31:0] wdata;
      logic [5:0]  ridx;
      logic [31:0] exp_rd;
      logic        exp_irq;
      logic        exp_fiq;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 18;
   // Write index 63 is unused, so those steps make no register change.
   localparam vec_t VEC [NV] = '{
      '{32'h0000_0000, 6'd63, 32'h0000_0000, 6'd1,  32'h0000_0000, 1'b0, 1'b0, 8'd2},  // R2 idle
      '{32'h0000_0030, 6'd2,  32'h0000_0010, 6'd2,  32'h0000_0010, 1'b1, 1'b0, 8'd3},  // R3
      '{32'h0000_0030, 6'd2,  32'h0000_0100, 6'd0,  32'h0000_0010, 1'b1, 1'b0, 8'd6},  // R6 R3 OR
      '{32'h0000_0020, 6'd10, 32'h0000_0020, 6'd8,  32'h0000_0020, 1'b0, 1'b1, 8'd6},  // R6 R8
      '{32'h0000_0020, 6'd11, 32'hFFFF_FFDF, 6'd10, 32'h0000_0020, 1'b0, 1'b1, 8'd5},  // R5 clear only ones
      '{32'h0000_0020, 6'd3,  32'h0000_0010, 6'd2,  32'h0000_0100, 1'b0, 1'b1, 8'd4},  // R4
      '{32'h0000_0000, 6'd4,  32'h0000_0002, 6'd4,  32'h0000_0000, 1'b0, 1'b0, 8'd9},  // R9 bit0 clear, R12 drop
      '{32'h0000_0000, 6'd4,  32'h0000_0001, 6'd1,  32'h0000_0001, 1'b0, 1'b0, 8'd9},  // R9 soft set
      '{32'h0000_0000, 6'd2,  32'h0000_0001, 6'd0,  32'h0000_0001, 1'b1, 1'b0, 8'd7},  // R7 soft source
      '{32'h0000_0000, 6'd0,  32'hFFFF_FFFF, 6'd2,  32'h0000_0101, 1'b1, 1'b0, 8'd11}, // R11 status write
      '{32'h0000_0000, 6'd9,  32'hFFFF_FFFF, 6'd10, 32'h0000_0020, 1'b1, 1'b0, 8'd11}, // R11 raw write
      '{32'h0000_0000, 6'd5,  32'h0000_0001, 6'd4,  32'h0000_0000, 1'b0, 1'b0, 8'd9},  // R9 soft clear
      '{32'h0000_0001, 6'd5,  32'h0000_0001, 6'd4,  32'h0000_0001, 1'b1, 1'b0, 8'd12}, // R12 hw bit0
      '{32'h0000_0001, 6'd63, 32'h0000_0000, 6'd3,  32'h0000_0000, 1'b1, 1'b0, 8'd10}, // R10
      '{32'h8000_0000, 6'd10, 32'h8000_0000, 6'd9,  32'h8000_0000, 1'b0, 1'b1, 8'd2},  // R2 top bit
      '{32'h8000_0000, 6'd7,  32'h0000_FFFF, 6'd5,  32'h0000_0000, 1'b0, 1'b1, 8'd10}, // R10 R11 unknown
      '{32'h0000_0000, 6'd11, 32'hFFFF_FFFF, 6'd11, 32'h0000_0000, 1'b0, 1'b0, 8'd5},  // R5 clear all
      '{32'h0000_0000, 6'd63, 32'h0000_0000, 6'd10, 32'h0000_0000, 1'b0, 1'b0, 8'd5}   // R5 mask empty
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
      end
   endtask

   task automatic rd_chk(input logic [5:0] ri, input logic [31:0] exp, input string tag);
      idx = ri;
      #1;
      chk(tag, rdata, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 irq in reset", {31'b0, irq}, 32'h0);
      chk("R1 fiq in reset", {31'b0, fiq}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk(6'd2,  32'h0, "R1 irq mask after reset");
      rd_chk(6'd10, 32'h0, "R1 fiq mask after reset");
      rd_chk(6'd4,  32'h0, "R1 soft flag after reset");

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         src = VEC[i].src; wr = 1'b1; idx = VEC[i].widx; wdata = VEC[i].wdata;
         @(negedge clk);
         wr = 1'b0; idx = VEC[i].ridx;
         @(negedge clk);
         chk($sformatf("R%0d vec%0d rdata", VEC[i].req, i), rdata, VEC[i].exp_rd);
         chk($sformatf("R7 vec%0d irq", i), {31'b0, irq}, {31'b0, VEC[i].exp_irq});
         chk($sformatf("R8 vec%0d fiq", i), {31'b0, fiq}, {31'b0, VEC[i].exp_fiq});
      end

      // R7 latency: irq mask now 0x101; raise source 1 then enable it.
      @(negedge clk);
      src = 32'h0000_0002; wr = 1'b1; idx = 6'd2; wdata = 32'h0000_0002;
      @(negedge clk);
      wr = 1'b0;
      chk("R7 irq not yet high one edge after enable", {31'b0, irq}, 32'h0);
      @(negedge clk);
      chk("R7 irq high two edges after enable", {31'b0, irq}, 32'h1);
      // R12 level drop
      src = 32'h0;
      rd_chk(6'd1, 32'h0, "R12 raw clears with line");
      @(negedge clk);
      chk("R12 irq low after line drop", {31'b0, irq}, 32'h0);

      // R1 reset in the middle of activity
      src = 32'h0000_0001; wr = 1'b1; idx = 6'd10; wdata = 32'h0000_0001;
      @(negedge clk);
      wr = 1'b1; idx = 6'd4; wdata = 32'h1;
      @(negedge clk);
      wr = 1'b0; src = 32'h0;
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 fiq cleared by reset", {31'b0, fiq}, 32'h0);
      chk("R1 irq cleared by reset", {31'b0, irq}, 32'h0);
      rd_chk(6'd10, 32'h0, "R1 fiq mask cleared by reset");
      rd_chk(6'd2,  32'h0, "R1 irq mask cleared by reset");
      rd_chk(6'd4,  32'h0, "R1 soft flag cleared by reset");
      rst_n = 1'b1;
      @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule